// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit forms a 32-bit effective address in one registered cycle from up to three terms: a base register value, an index register value shifted left by a power-of-two scale, and a signed displacement. Each term has its own enable, so one datapath covers four addressing forms: base with displacement, base with index, base with scaled index, and base with scaled index and displacement. A displacement is either a full 32-bit immediate or a short 8-bit immediate that is sign-extended.

Every request is flagged either as a memory operand or as a load-address request. For a load-address request the computed address is itself the result. The unit marks it that way and does not raise its memory-read request. The sum wraps modulo 2^32, and the result appears on the cycle after the request strobe.

Top module: `eaddr_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released with no request, out_valid, out_is_lea and out_mem_rd are 0 and out_addr is 0.
- R2: out_valid equals in_valid delayed by exactly one clock cycle.
- R3: With base_en=1, idx_en=0 and disp_en=1, disp_short=0, out_addr = base_val + disp_val.
- R4: With disp_short=1 the displacement term is disp_val[7:0] sign-extended from bit 7 to 32 bits, and disp_val[31:8] has no effect.
- R5: With idx_en=1 the index term is idx_val shifted left by scale_code: code 0 gives ×1, 1 gives ×2, 2 gives ×4, 3 gives ×8. Bits shifted past bit 31 are lost.
- R6: With idx_en=0 the index term is zero for every scale_code and idx_val.
- R7: With base_en=0 the base term is zero, and with disp_en=0 the displacement term is zero. This allows base+index and scaled-index forms with no displacement.
- R8: The three-term sum wraps modulo 2^32, and no carry out of bit 31 is observable.
- R9: A request with lea_req=1 gives out_is_lea=1 and out_mem_rd=0 on the following cycle. A request with lea_req=0 gives out_is_lea=0 and out_mem_rd=1.
- R10: A cycle with in_valid=0 leaves out_addr unchanged and sets out_is_lea=0 and out_mem_rd=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| lea_req | input | 1 | 1 = load-address request, 0 = memory operand |
| base_en | input | 1 | Include the base term |
| base_val | input | 32 | Base register value |
| idx_en | input | 1 | Include the index term |
| idx_val | input | 32 | Index register value |
| scale_code | input | 2 | Index left-shift amount (0..3) |
| disp_en | input | 1 | Include the displacement term |
| disp_short | input | 1 | 1 = sign-extend disp_val[7:0], 0 = use full disp_val |
| disp_val | input | 32 | Displacement immediate |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective address |
| out_is_lea | output | 1 | Result belongs to a load-address request |
| out_mem_rd | output | 1 | Result should be used for a memory read |

## Verification
The assertions assume that rst_n is driven low for at least one clock before any request is checked. They also assume that the inputs are stable around the rising edge, because they compare the registered outputs against the inputs sampled one edge earlier. The bench drives every input on the falling edge and samples on the following falling edge, so each check sees exactly one register stage. The random phase draws every enable, the scale code, the short/long displacement choice and the load-address flag independently. Some draws have in_valid low, which exercises the hold behaviour between requests.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
    localparam int unsigned EA_W    = 32;
    localparam int unsigned SHORT_W = 8;
    localparam int unsigned SCALE_W = 2;

    typedef struct packed {
        logic            valid;
        logic            is_lea;
        logic            mem_rd;
        logic [EA_W-1:0] addr;
    } ea_state_t;
endpackage

// File: rtl/eaddr_disp_ext.sv
module eaddr_disp_ext #(
    parameter int unsigned W       = 32,
    parameter int unsigned SHORT_W = 8
) (
    input  logic [W-1:0] disp_raw,
    input  logic         use_short,
    input  logic         disp_on,
    output logic [W-1:0] disp_term
);
    localparam int unsigned EXT_W = W - SHORT_W;

    always_comb begin
        if (!disp_on) begin
            disp_term = '0;
        end else if (use_short) begin
            disp_term = {{EXT_W{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
        end else begin
            disp_term = disp_raw;
        end
    end
endmodule

// File: rtl/eaddr_idx_scale.sv
module eaddr_idx_scale #(
    parameter int unsigned W    = 32,
    parameter int unsigned SC_W = 2
) (
    input  logic [W-1:0]    idx_raw,
    input  logic            idx_on,
    input  logic [SC_W-1:0] scale_sel,
    output logic [W-1:0]    idx_term
);
    localparam int unsigned N_SCALES = 1 << SC_W;

    logic [W-1:0] shifted [N_SCALES];

    for (genvar g = 0; g < N_SCALES; g++) begin : g_shift
        assign shifted[g] = idx_raw << g;
    end

    assign idx_term = idx_on ? shifted[scale_sel] : '0;
endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
    import eaddr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                lea_req,
    input  logic                base_en,
    input  logic [EA_W-1:0]     base_val,
    input  logic                idx_en,
    input  logic [EA_W-1:0]     idx_val,
    input  logic [SCALE_W-1:0]  scale_code,
    input  logic                disp_en,
    input  logic                disp_short,
    input  logic [EA_W-1:0]     disp_val,
    output logic                out_valid,
    output logic [EA_W-1:0]     out_addr,
    output logic                out_is_lea,
    output logic                out_mem_rd
);
    logic [EA_W-1:0] base_term;
    logic [EA_W-1:0] idx_term;
    logic [EA_W-1:0] disp_term;
    ea_state_t       st_d;
    ea_state_t       st_q;

    eaddr_idx_scale #(.W(EA_W), .SC_W(SCALE_W)) idx_scale_i (
        .idx_raw   (idx_val),
        .idx_on    (idx_en),
        .scale_sel (scale_code),
        .idx_term  (idx_term)
    );

    eaddr_disp_ext #(.W(EA_W), .SHORT_W(SHORT_W)) disp_ext_i (
        .disp_raw  (disp_val),
        .use_short (disp_short),
        .disp_on   (disp_en),
        .disp_term (disp_term)
    );

    assign base_term = base_en ? base_val : '0;

    always_comb begin
        st_d        = st_q;
        st_d.valid  = in_valid;
        st_d.is_lea = in_valid & lea_req;
        st_d.mem_rd = in_valid & ~lea_req;
        if (in_valid) begin
            st_d.addr = base_term + idx_term + disp_term;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_addr   = st_q.addr;
    assign out_is_lea = st_q.is_lea;
    assign out_mem_rd = st_q.mem_rd;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_lea_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lea_req) |=> (out_is_lea && !out_mem_rd));
    a_r9_mem_read: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lea_req) |=> (out_mem_rd && !out_is_lea));
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));
    a_r6_all_terms_off: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !base_en && !idx_en && !disp_en) |=> (out_addr == '0));
    a_r5_scale_eight: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !base_en && idx_en && !disp_en && scale_code == 2'd3)
        |=> (out_addr == ($past(idx_val) << 3)));
endmodule

// File: tb/eaddr_unit_tb.sv
module eaddr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        lea_req = 1'b0;
    logic        base_en = 1'b0;
    logic [31:0] base_val = '0;
    logic        idx_en = 1'b0;
    logic [31:0] idx_val = '0;
    logic [1:0]  scale_code = '0;
    logic        disp_en = 1'b0;
    logic        disp_short = 1'b0;
    logic [31:0] disp_val = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_is_lea;
    logic        out_mem_rd;

    int total = 0;
    int bad   = 0;
    logic [31:0] last_addr = '0;

    always #2 clk = ~clk;

    eaddr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lea_req(lea_req),
        .base_en(base_en), .base_val(base_val), .idx_en(idx_en), .idx_val(idx_val),
        .scale_code(scale_code), .disp_en(disp_en), .disp_short(disp_short),
        .disp_val(disp_val), .out_valid(out_valid), .out_addr(out_addr),
        .out_is_lea(out_is_lea), .out_mem_rd(out_mem_rd)
    );

    function automatic logic [31:0] model_addr(
        logic be, logic [31:0] b, logic ie, logic [31:0] i, logic [1:0] sc,
        logic de, logic ds, logic [31:0] d);
        logic [31:0] bt, it, dt;
        bt = be ? b : 32'd0;
        it = ie ? (i * (32'd1 << sc)) : 32'd0;
        if (!de)     dt = 32'd0;
        else if (ds) dt = 32'(signed'(d[7:0]));
        else         dt = d;
        return bt + it + dt;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic lea, input logic be, input logic [31:0] b,
                        input logic ie, input logic [31:0] i, input logic [1:0] sc,
                        input logic de, input logic ds, input logic [31:0] d, input string req);
        logic [31:0] exp;
        in_valid = v; lea_req = lea; base_en = be; base_val = b; idx_en = ie;
        idx_val = i; scale_code = sc; disp_en = de; disp_short = ds; disp_val = d;
        exp = v ? model_addr(be, b, ie, i, sc, de, ds, d) : last_addr;
        @(negedge clk);
        chk({req, " addr"}, out_addr, exp);
        chk("R2 valid", {31'd0, out_valid}, {31'd0, v});
        chk("R9 lea flag", {31'd0, out_is_lea}, {31'd0, v & lea});
        chk("R9 mem read", {31'd0, out_mem_rd}, {31'd0, v & ~lea});
        last_addr = exp;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset addr", out_addr, 32'd0);
        chk("R1 reset rd", {31'd0, out_mem_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release addr", out_addr, 32'd0);
        chk("R1 after release lea", {31'd0, out_is_lea}, 32'd0);

        step(1, 0, 1, 32'h1000_0000, 0, 32'hFFFF_FFFF, 2'd3, 1, 0, 32'h0000_1234, "R3 base+disp");
        step(1, 0, 1, 32'h0000_0100, 0, 0, 0, 1, 1, 32'hABCD_EF80, "R4 short neg");
        chk("R4 value", out_addr, 32'h0000_0080);
        step(1, 0, 1, 32'h0000_0100, 0, 0, 0, 1, 1, 32'h1234_567F, "R4 short pos");
        for (int s = 0; s < 4; s++) begin
            step(1, 0, 1, 32'h0000_1000, 1, 32'h0000_0011, 2'(s), 0, 0, 32'h5555_5555, "R5 scale");
        end
        step(1, 0, 0, 0, 1, 32'hF000_0001, 2'd3, 0, 0, 0, "R5 shift-out");
        chk("R5 value", out_addr, 32'h8000_0008);
        step(1, 0, 1, 32'h0000_2000, 0, 32'h0000_0777, 2'd3, 0, 0, 0, "R6 index off");
        chk("R6 value", out_addr, 32'h0000_2000);
        step(1, 0, 0, 32'hDEAD_BEEF, 1, 32'h0000_0004, 2'd1, 1, 0, 32'h10, "R7 base off");
        step(1, 0, 1, 32'h0000_0040, 1, 32'h0000_0004, 2'd0, 0, 0, 32'hFFFF, "R7 disp off");
        step(1, 0, 1, 32'hFFFF_FFF0, 1, 32'h0000_0008, 2'd2, 1, 0, 32'h0000_0000, "R8 wrap");
        chk("R8 value", out_addr, 32'h0000_0010);
        step(1, 1, 1, 32'h0001_0000, 1, 32'h0000_0003, 2'd2, 1, 1, 32'h0000_00FC, "R9 lea");
        step(0, 1, 1, 32'h7777_7777, 1, 32'h1, 2'd1, 1, 0, 32'h9, "R10 hold");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 hold again");

        for (int n = 0; n < 400; n++) begin
            step(($urandom % 4) != 0, 1'($urandom), 1'($urandom), $urandom,
                 1'($urandom), $urandom, 2'($urandom), 1'($urandom), 1'($urandom),
                 $urandom, "R3 R4 R5 R6 R7 R8 R10 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule